// File: doc/BRIEF.md
# Sound Envelope Level Generator

This block produces the 5-bit envelope level that a three-voice programmable sound generator applies to any voice set to envelope-controlled loudness. The surrounding generator supplies a one-cycle enable at its prescaled sound rate. A 16-bit period divider thins that enable into envelope steps, and each step moves a 6-bit position counter forward. The level is then decoded from the position and from the 4-bit shape code that was written last.

The sixteen shape codes collapse onto eight behaviours. Two are one-shot ramps that fall or rise and then stay silent. Two are saw waves that repeat. Two are triangles that repeat. Two are ramps that fall or rise and then stay at full level. The one-shot shapes stop on the last step of the position count, and the repeating ones wrap back to zero. Writing a shape code starts the envelope again from position zero.

A mode input forces the lowest position bit high before the decode. This emulates a coarser 16-level part on the same 32-step datapath.

Top module: `psg_env_gen`

## Requirements
- R1: While `rst` is high on a clock edge, the level output, the position, the latched shape (code 0) and the divider count are all cleared to zero.
- R2: On a cycle with `tick_en` high, a divider count of zero produces an envelope step and reloads the count from `period_i`. A nonzero count is decremented and produces no step. Without `tick_en` the count holds. Steps therefore arrive every `period_i`+1 ticks.
- R3: Each step advances the 6-bit position by one.
- R4: A step at position 63 reloads the position. It reloads 63 for shapes 0–7, 9, 11, 13 and 15, which stay on the last step. It reloads 0 for shapes 8, 10, 12 and 14, which repeat.
- R5: A cycle with `shape_wr` high latches `shape_i` and sets the position to 0. When a step falls in the same cycle, the write takes priority and the position becomes 0.
- R6: Shapes 0–3 and 9 give 31−p for positions p below 32, and 0 from position 32 onward.
- R7: Shapes 4–7 and 15 give p for positions below 32, and 0 from position 32 onward.
- R8: Shape 8 is a falling saw, 31−(p mod 32). Shape 12 is a rising saw, p mod 32.
- R9: Shape 10 gives 31−(p mod 32) in the lower half of the position range and p mod 32 in the upper half. Shape 14 gives the reverse.
- R10: Shape 11 falls as 31−p and then holds at 31 from position 32. Shape 13 rises as p and then holds at 31 from position 32.
- R11: With `coarse_i` high, bit 0 of the position is forced to 1 before the decode. The stored position is unchanged.
- R12: `level_o` is registered. It shows the decode of the position and shape held in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle prescaled sound tick |
| period_i | input | 16 | Envelope period (ticks per step minus one) |
| shape_wr | input | 1 | Shape write strobe, restarts the envelope |
| shape_i | input | 4 | Shape code written on `shape_wr` |
| coarse_i | input | 1 | 16-level emulation mode |
| level_o | output | 5 | Envelope level |

## Verification
A shape write and an envelope step can land in the same cycle. They compete for the position register, and the write must win. The bench first advances a rising saw to a known position while the divider count sits at zero. It then raises `shape_wr` and `tick_en` on the same edge. The registered level one cycle later must read 0, not the old position plus one, and the next lone tick must then give level 1.

// File: rtl/psg_env_pkg.sv
package psg_env_pkg;

  localparam int PER_W   = 16;
  localparam int POS_W   = 6;
  localparam int SHAPE_W = 4;
  localparam int LVL_W   = POS_W - 1;

  typedef enum logic [2:0] {
    BH_DECAY     = 3'd0,
    BH_ATTACK    = 3'd1,
    BH_SAW_DN    = 3'd2,
    BH_SAW_UP    = 3'd3,
    BH_TRI_DN    = 3'd4,
    BH_TRI_UP    = 3'd5,
    BH_FALL_HOLD = 3'd6,
    BH_RISE_HOLD = 3'd7
  } env_bhv_e;

  function automatic env_bhv_e shape_to_bhv(input logic [SHAPE_W-1:0] code);
    env_bhv_e b;
    if (code[3] == 1'b0) begin
      b = code[2] ? BH_ATTACK : BH_DECAY;
    end else begin
      case (code[2:0])
        3'd0:    b = BH_SAW_DN;
        3'd1:    b = BH_DECAY;
        3'd2:    b = BH_TRI_DN;
        3'd3:    b = BH_FALL_HOLD;
        3'd4:    b = BH_SAW_UP;
        3'd5:    b = BH_RISE_HOLD;
        3'd6:    b = BH_TRI_UP;
        default: b = BH_ATTACK;
      endcase
    end
    return b;
  endfunction

  function automatic logic bhv_repeats(input env_bhv_e b);
    return (b == BH_SAW_DN) || (b == BH_SAW_UP) ||
           (b == BH_TRI_DN) || (b == BH_TRI_UP);
  endfunction

endpackage

// File: rtl/psg_env_div.sv
module psg_env_div #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [PER_W-1:0] period_i,
  output logic             step_o,
  output logic [PER_W-1:0] cnt_o
);

  logic [PER_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign step_o  = tick_en && at_zero;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      if (at_zero) cnt_q <= period_i;
      else         cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/psg_env_pos.sv
module psg_env_pos #(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic             hold_at_end,
  output logic [POS_W-1:0] pos_o
);

  localparam logic [POS_W-1:0] POS_LAST = '1;

  logic [POS_W-1:0] pos_q;

  assign pos_o = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (restart) begin
      pos_q <= '0;
    end else if (step) begin
      if (pos_q == POS_LAST) pos_q <= hold_at_end ? POS_LAST : '0;
      else                   pos_q <= pos_q + 1'b1;
    end
  end

endmodule

// File: rtl/psg_env_lut.sv
module psg_env_lut
  import psg_env_pkg::*;
#(
  parameter int POS_W = 6,
  parameter int LVL_W = POS_W - 1
) (
  input  logic [POS_W-1:0] pos_i,
  input  env_bhv_e         bhv_i,
  output logic [LVL_W-1:0] level_o
);

  logic             upper;
  logic [LVL_W-1:0] rise;
  logic [LVL_W-1:0] fall;

  assign upper = pos_i[POS_W-1];
  assign rise  = pos_i[LVL_W-1:0];
  assign fall  = ~pos_i[LVL_W-1:0];

  always_comb begin
    case (bhv_i)
      BH_DECAY:     level_o = upper ? '0 : fall;
      BH_ATTACK:    level_o = upper ? '0 : rise;
      BH_SAW_DN:    level_o = fall;
      BH_SAW_UP:    level_o = rise;
      BH_TRI_DN:    level_o = upper ? rise : fall;
      BH_TRI_UP:    level_o = upper ? fall : rise;
      BH_FALL_HOLD: level_o = upper ? '1 : fall;
      default:      level_o = upper ? '1 : rise;
    endcase
  end

endmodule

// File: rtl/psg_env_gen.sv
module psg_env_gen
  import psg_env_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic [PER_W-1:0]   period_i,
  input  logic               shape_wr,
  input  logic [SHAPE_W-1:0] shape_i,
  input  logic               coarse_i,
  output logic [LVL_W-1:0]   level_o
);

  logic [SHAPE_W-1:0] shape_q;
  env_bhv_e           bhv;
  logic               step;
  logic [PER_W-1:0]   cnt;
  logic [POS_W-1:0]   pos_q;
  logic [POS_W-1:0]   pos_lk;
  logic [LVL_W-1:0]   lvl_next;
  logic [LVL_W-1:0]   level_q;

  assign bhv    = shape_to_bhv(shape_q);
  assign pos_lk = {pos_q[POS_W-1:1], pos_q[0] | coarse_i};

  always_ff @(posedge clk) begin
    if (rst)           shape_q <= '0;
    else if (shape_wr) shape_q <= shape_i;
  end

  psg_env_div #(.PER_W(PER_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .period_i (period_i),
    .step_o   (step),
    .cnt_o    (cnt)
  );

  psg_env_pos #(.POS_W(POS_W)) u_pos (
    .clk         (clk),
    .rst         (rst),
    .restart     (shape_wr),
    .step        (step),
    .hold_at_end (!bhv_repeats(bhv)),
    .pos_o       (pos_q)
  );

  psg_env_lut #(.POS_W(POS_W), .LVL_W(LVL_W)) u_lut (
    .pos_i   (pos_lk),
    .bhv_i   (bhv),
    .level_o (lvl_next)
  );

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= lvl_next;
  end

  assign level_o = level_q;

endmodule

// File: rtl/psg_env_chk.sv
module psg_env_chk
  import psg_env_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               tick_en,
  input logic               shape_wr,
  input logic [PER_W-1:0]   period_i,
  input logic [PER_W-1:0]   cnt,
  input logic               step,
  input logic [POS_W-1:0]   pos_q,
  input logic [SHAPE_W-1:0] shape_q,
  input logic [LVL_W-1:0]   level_o
);

  logic rep_shape;
  logic zero_tail;
  logic high_tail;
  assign rep_shape = (shape_q == 4'd8) || (shape_q == 4'd10) ||
                     (shape_q == 4'd12) || (shape_q == 4'd14);
  assign zero_tail = (shape_q <= 4'd7) || (shape_q == 4'd9) || (shape_q == 4'd15);
  assign high_tail = (shape_q == 4'd11) || (shape_q == 4'd13);

  // R2
  div_dec_chk: assert property (@(posedge clk) disable iff (rst)
    tick_en && cnt != '0 |=> cnt == $past(cnt) - 1'b1);

  // R2
  div_reload_chk: assert property (@(posedge clk) disable iff (rst)
    tick_en && cnt == '0 |=> cnt == $past(period_i));

  // R2
  div_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt));

  // R3
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    step && !shape_wr && pos_q != '1 |=> pos_q == $past(pos_q) + 1'b1);

  // R3
  pos_still_chk: assert property (@(posedge clk) disable iff (rst)
    !step && !shape_wr |=> $stable(pos_q));

  // R4
  wrap_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    step && !shape_wr && pos_q == '1 && rep_shape |=> pos_q == '0);

  // R4
  wrap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    step && !shape_wr && pos_q == '1 && !rep_shape |=> pos_q == '1);

  // R5
  write_restart_chk: assert property (@(posedge clk) disable iff (rst)
    shape_wr |=> pos_q == '0);

  // R6
  zero_tail_chk: assert property (@(posedge clk) disable iff (rst)
    zero_tail && pos_q[POS_W-1] |=> level_o == '0);

  // R10
  high_tail_chk: assert property (@(posedge clk) disable iff (rst)
    high_tail && pos_q[POS_W-1] |=> level_o == '1);

endmodule

bind psg_env_gen psg_env_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .shape_wr (shape_wr),
  .period_i (period_i),
  .cnt      (cnt),
  .step     (step),
  .pos_q    (pos_q),
  .shape_q  (shape_q),
  .level_o  (level_o)
);

// File: tb/psg_env_gen_bench.sv
module psg_env_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [15:0] period_i = '0;
  logic        shape_wr = 1'b0;
  logic [3:0]  shape_i = '0;
  logic        coarse_i = 1'b0;
  logic [4:0]  level_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  psg_env_gen u_psg_env_gen (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .period_i (period_i),
    .shape_wr (shape_wr),
    .shape_i  (shape_i),
    .coarse_i (coarse_i),
    .level_o  (level_o)
  );

  // {req[3:0], shape[3:0], coarse, steps[7:0], expected[4:0]}
  localparam int NV = 24;
  localparam logic [21:0] VEC [0:NV-1] = '{
    {4'd6,  4'd0,  1'b0, 8'd0,  5'd31}, // R6 start of decay
    {4'd6,  4'd0,  1'b0, 8'd5,  5'd26}, // R6
    {4'd6,  4'd0,  1'b0, 8'd40, 5'd0},  // R6 silent tail
    {4'd4,  4'd0,  1'b0, 8'd70, 5'd0},  // R4 hold after overflow
    {4'd6,  4'd2,  1'b0, 8'd20, 5'd11}, // R6
    {4'd4,  4'd9,  1'b0, 8'd70, 5'd0},  // R4
    {4'd7,  4'd4,  1'b0, 8'd10, 5'd10}, // R7
    {4'd7,  4'd6,  1'b0, 8'd20, 5'd20}, // R7
    {4'd4,  4'd4,  1'b0, 8'd70, 5'd0},  // R4
    {4'd4,  4'd15, 1'b0, 8'd70, 5'd0},  // R4
    {4'd8,  4'd8,  1'b0, 8'd40, 5'd23}, // R8 falling saw
    {4'd4,  4'd8,  1'b0, 8'd70, 5'd25}, // R4 saw wrapped to 6
    {4'd8,  4'd12, 1'b0, 8'd37, 5'd5},  // R8 rising saw
    {4'd4,  4'd12, 1'b0, 8'd66, 5'd2},  // R4
    {4'd9,  4'd10, 1'b0, 8'd3,  5'd28}, // R9
    {4'd9,  4'd10, 1'b0, 8'd35, 5'd3},  // R9
    {4'd4,  4'd10, 1'b0, 8'd66, 5'd29}, // R4 triangle wrapped
    {4'd9,  4'd14, 1'b0, 8'd3,  5'd3},  // R9
    {4'd9,  4'd14, 1'b0, 8'd35, 5'd28}, // R9
    {4'd10, 4'd11, 1'b0, 8'd10, 5'd21}, // R10
    {4'd10, 4'd11, 1'b0, 8'd70, 5'd31}, // R10 held high
    {4'd10, 4'd13, 1'b0, 8'd70, 5'd31}, // R10
    {4'd11, 4'd4,  1'b1, 8'd10, 5'd11}, // R11 bit 0 forced
    {4'd11, 4'd0,  1'b1, 8'd4,  5'd26}  // R11
  };

  task automatic check(input string req, input logic [4:0] exp);
    checks++;
    if (level_o !== exp) begin
      errors++;
      $display("FAIL %s: level_o actual %0d expected %0d", req, level_o, exp);
    end
  endtask

  task automatic write_shape(input logic [3:0] s);
    @(negedge clk);
    shape_wr = 1'b1;
    shape_i  = s;
    @(negedge clk);
    shape_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", 5'd0);
    rst = 1'b0;
    @(negedge clk);
    // R12: one cycle after reset, shape 0 at position 0 decodes to 31
    check("R12", 5'd31);

    for (int v = 0; v < NV; v++) begin
      coarse_i = VEC[v][13];
      write_shape(VEC[v][17:14]);
      ticks(int'(VEC[v][12:5]));
      @(negedge clk);
      checks++;
      if (level_o !== VEC[v][4:0]) begin
        errors++;
        $display("FAIL R%0d: vector %0d level_o actual %0d expected %0d",
                 VEC[v][21:18], v, level_o, VEC[v][4:0]);
      end
    end
    coarse_i = 1'b0;

    // R5: write and step in the same cycle, write wins
    write_shape(4'd12);
    ticks(5);
    @(negedge clk);
    check("R3", 5'd5);
    shape_wr = 1'b1;
    shape_i  = 4'd12;
    tick_en  = 1'b1;
    @(negedge clk);
    shape_wr = 1'b0;
    tick_en  = 1'b0;
    @(negedge clk);
    check("R5", 5'd0);
    ticks(1);
    @(negedge clk);
    check("R5", 5'd1);

    // R11: coarse mode leaves stored position alone
    coarse_i = 1'b1;
    @(negedge clk);
    check("R11", 5'd1);
    ticks(1);
    @(negedge clk);
    check("R11", 5'd3);
    coarse_i = 1'b0;
    @(negedge clk);
    check("R11", 5'd2);

    // R2: period 2 gives a step every third tick; idle clocks hold
    write_shape(4'd12);
    period_i = 16'd2;
    ticks(1);
    @(negedge clk);
    check("R2", 5'd1);
    repeat (5) @(negedge clk);
    check("R2", 5'd1);
    ticks(2);
    @(negedge clk);
    check("R2", 5'd1);
    ticks(1);
    @(negedge clk);
    check("R2", 5'd2);

    // R1: reset mid-run clears level and position
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", 5'd0);
    rst = 1'b0;
    period_i = '0;
    @(negedge clk);
    check("R1", 5'd31);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule